// File: doc/BRIEF.md
# Segmented Virtual Address Translator

This block turns a 16-bit virtual address into an 18-bit or 22-bit physical address. The top three virtual address bits pick one of eight segments. The chosen segment's base register, counted in 64-byte units, is shifted left by six and added to the low 13 bits of the virtual address. Each of three processor modes (kernel, supervisor, user) owns two banks of eight descriptor/base pairs: one for instruction references and one for data references. Each mode also has an enable that decides whether data references use the data bank at all.

Software reaches the 96 segment registers and two control words through a word-wide register port. Writes are synchronous and reads are combinational. A bus reset clears both control words, which switches translation off. With translation off, the virtual address passes straight through, except that the top 8 KB of virtual space is forced onto the I/O page at the top of physical memory. A previous-mode select lets cross-space move operations translate with another mode's registers. The translated address is registered, so it appears one clock after the inputs are presented.

Top module: `seg_xlat`

## Requirements
- R1: While `rst` is high and after it is released, `physAddr` is 0 and both control words read 0.
- R2: Control word A is at `regAddr` 8'h80. Only bits 0 (translation enable), 4 (split-space flag) and 8 (maintenance flag) are stored, so writing 16'hFFFF reads back 16'h0111. Control word B is at 8'h81. Only bits 0 (user data bank), 1 (supervisor data bank), 2 (kernel data bank), 4 (22-bit mode) and 5 (bus-map flag) are stored, so writing 16'hFFFF reads back 16'h0037. Writing one control word leaves the other unchanged.
- R3: Segment registers sit where `regAddr[7]`=0. In that range, bit 6 selects base (1) or descriptor (0), bits 5:4 give the mode (0 kernel, 1 supervisor, 2 user, 3 is an alias of user), bit 3 selects the data bank and bits 2:0 give the segment. Base registers keep all 16 bits. Descriptors keep only the bits in mask 16'o077417.
- R4: With translation off, `physAddr` equals `vaddr`. When `vaddr[15:13]` is 7, the bits above bit 15 are also forced to 1: 2 bits in 18-bit mode and 6 bits in 22-bit mode.
- R5: With translation on, `physAddr` = (base << 6) + `vaddr[12:0]`. The base comes from the register chosen by the mode, the bank and the segment `vaddr[15:13]`. Raising a base by 1 moves the window up by 64 bytes.
- R6: A data reference (`isData`=1) uses the data bank only when the data-bank bit of the effective mode is set. Otherwise it uses that mode's instruction bank.
- R7: In 18-bit mode the sum is cut to 18 bits and bits 21:18 are 0, so the upper four base bits have no effect.
- R8: In 22-bit mode the full 22-bit sum is output. A kernel segment-7 base of 16'o177600 maps virtual 16'o160000 to 22'o17760000.
- R9: A one-cycle `busReset` pulse clears both control words, and translation then falls back to the pass-through of R4.
- R10: When `usePrev` is 1, `prevMode` replaces `curMode` for both register selection and the data-bank enable.
- R11: `physAddr` reflects the inputs present at the previous rising clock edge and holds between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busReset | input | 1 | System reset pulse that clears the control words |
| curMode | input | 2 | Current mode: 0 kernel, 1 supervisor, 2/3 user |
| prevMode | input | 2 | Previous mode, same encoding |
| usePrev | input | 1 | Translate with `prevMode` instead of `curMode` |
| isData | input | 1 | Reference is a data access |
| vaddr | input | 16 | Virtual address |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 8 | Register select |
| regWData | input | 16 | Register write data |
| regRData | output | 16 | Register read data (combinational) |
| physAddr | output | 22 | Registered physical address |

## Verification
The translated address is due exactly one rising edge after the virtual address, mode and control inputs are presented. Register read-back is combinational from `regAddr`. Register and control writes only take effect at the next edge, so a translation presented together with a write still uses the old values. The bench drives every input on the falling edge and samples `physAddr` one time unit after the following rising edge. It reads registers before any edge. One directed case also samples just before the edge to confirm the output still holds its previous value.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;
  localparam int REG_W    = 16;
  localparam int SEG_BITS = 3;
  localparam int MODES    = 3;
  localparam int BANK_IDX_W = 6;  // mode(2) + space(1) + segment(3)

  typedef struct packed {
    logic                  descWe;
    logic                  baseWe;
    logic                  rdIsBase;
    logic [BANK_IDX_W-1:0] bankIdx;
  } bankStrobe_t;
endpackage

// File: rtl/seg_xlat_ctrl.sv
module seg_xlat_ctrl
  import seg_xlat_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [REG_W-1:0] CTRL_A_MASK = 16'h0111,
  parameter logic [REG_W-1:0] CTRL_B_MASK = 16'h0037
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busReset,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWData,
  input  logic [REG_W-1:0]  bankRData,
  output bankStrobe_t       strobe,
  output logic              mapEn,
  output logic              ext22,
  output logic [MODES-1:0]  dspEn,
  output logic [REG_W-1:0]  regRData
);
  localparam logic [ADDR_W-1:0] CTRL_A_ADDR = ADDR_W'(8'h80);
  localparam logic [ADDR_W-1:0] CTRL_B_ADDR = ADDR_W'(8'h81);

  logic [REG_W-1:0] ctrlA, ctrlB;
  logic             isSegReg;
  logic [1:0]       modeIdx;

  assign isSegReg = ~regAddr[ADDR_W-1];
  assign modeIdx  = (regAddr[5:4] == 2'd3) ? 2'd2 : regAddr[5:4];

  always_comb begin
    strobe.bankIdx  = {modeIdx, regAddr[3], regAddr[SEG_BITS-1:0]};
    strobe.rdIsBase = regAddr[6];
    strobe.descWe   = regWe & isSegReg & ~regAddr[6];
    strobe.baseWe   = regWe & isSegReg &  regAddr[6];
  end

  always_ff @(posedge clk) begin
    if (rst || busReset) begin
      ctrlA <= '0;
      ctrlB <= '0;
    end else if (regWe) begin
      if (regAddr == CTRL_A_ADDR) ctrlA <= regWData & CTRL_A_MASK;
      if (regAddr == CTRL_B_ADDR) ctrlB <= regWData & CTRL_B_MASK;
    end
  end

  // control word B: bit0 user, bit1 supervisor, bit2 kernel; dspEn indexed by mode
  assign mapEn    = ctrlA[0];
  assign ext22    = ctrlB[4];
  assign dspEn[0] = ctrlB[2];
  assign dspEn[1] = ctrlB[1];
  assign dspEn[2] = ctrlB[0];

  always_comb begin
    if (isSegReg)                  regRData = bankRData;
    else if (regAddr == CTRL_A_ADDR) regRData = ctrlA;
    else if (regAddr == CTRL_B_ADDR) regRData = ctrlB;
    else                           regRData = '0;
  end

  // R9: bus reset pulse empties both control words
  p_bus_reset_clears_r9: assert property (@(posedge clk) disable iff (rst)
    busReset |=> (ctrlA == '0) && (ctrlB == '0));

  // R2: a write to word A leaves word B alone
  p_ctrl_independent_r2: assert property (@(posedge clk) disable iff (rst)
    (regWe && regAddr == CTRL_A_ADDR && !busReset) |=> $stable(ctrlB));
endmodule

// File: rtl/seg_xlat_path.sv
module seg_xlat_path
  import seg_xlat_pkg::*;
#(
  parameter int VA_W     = 16,
  parameter int CLICK_W  = 6,
  parameter int NARROW_W = 18,
  parameter logic [REG_W-1:0] DESC_MASK = 16'o077417
) (
  input  logic             clk,
  input  logic             rst,
  input  bankStrobe_t      strobe,
  input  logic [REG_W-1:0] regWData,
  output logic [REG_W-1:0] bankRData,
  input  logic             mapEn,
  input  logic             ext22,
  input  logic [MODES-1:0] dspEn,
  input  logic [1:0]       curMode,
  input  logic [1:0]       prevMode,
  input  logic             usePrev,
  input  logic             isData,
  input  logic [VA_W-1:0]  vaddr,
  output logic [REG_W+CLICK_W-1:0] physAddr
);
  localparam int PA_W    = REG_W + CLICK_W;
  localparam int OFF_W   = VA_W - SEG_BITS;
  localparam int ENTRIES = MODES * 2 * (1 << SEG_BITS);

  logic [REG_W-1:0] descMem [ENTRIES];
  logic [REG_W-1:0] baseMem [ENTRIES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) begin
        descMem[i] <= '0;
        baseMem[i] <= '0;
      end
    end else begin
      if (strobe.descWe) descMem[strobe.bankIdx] <= regWData & DESC_MASK;
      if (strobe.baseWe) baseMem[strobe.bankIdx] <= regWData;
    end
  end

  assign bankRData = strobe.rdIsBase ? baseMem[strobe.bankIdx] : descMem[strobe.bankIdx];

  logic [1:0]            effMode, modeSel;
  logic                  useDBank;
  logic [BANK_IDX_W-1:0] xIdx;
  logic [REG_W-1:0]      segBase;
  logic [PA_W-1:0]       mappedAddr, flatAddr, fullAddr, nextPhys;
  logic                  ioSeg;

  always_comb begin
    effMode    = usePrev ? prevMode : curMode;
    modeSel    = (effMode == 2'd3) ? 2'd2 : effMode;
    useDBank   = isData & dspEn[modeSel];
    xIdx       = {modeSel, useDBank, vaddr[VA_W-1 -: SEG_BITS]};
    segBase    = baseMem[xIdx];
    mappedAddr = {segBase, {CLICK_W{1'b0}}} + PA_W'(vaddr[OFF_W-1:0]);
    ioSeg      = &vaddr[VA_W-1 -: SEG_BITS];
    flatAddr   = ioSeg ? {{(PA_W-VA_W){1'b1}}, vaddr} : PA_W'(vaddr);
    fullAddr   = mapEn ? mappedAddr : flatAddr;
    nextPhys   = ext22 ? fullAddr : PA_W'(fullAddr[NARROW_W-1:0]);
  end

  always_ff @(posedge clk) begin
    if (rst) physAddr <= '0;
    else     physAddr <= nextPhys;
  end

  // R4: pass-through below the I/O segment when translation is off
  p_flat_pass_r4: assert property (@(posedge clk) disable iff (rst)
    (!mapEn && !(&vaddr[VA_W-1 -: SEG_BITS])) |=>
      (physAddr == PA_W'($past(vaddr))));

  // R4: I/O segment lands on top of physical memory when translation is off
  p_flat_io_r4: assert property (@(posedge clk) disable iff (rst)
    (!mapEn && (&vaddr[VA_W-1 -: SEG_BITS])) |=>
      (&physAddr[NARROW_W-1:VA_W]));

  // R7: narrow mode never drives the upper address bits
  p_narrow_clear_r7: assert property (@(posedge clk) disable iff (rst)
    !ext22 |=> (physAddr[PA_W-1:NARROW_W] == '0));

  // R5: the byte offset inside a 64-byte click passes unchanged
  p_click_offset_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (physAddr[CLICK_W-1:0] == $past(vaddr[CLICK_W-1:0])));
endmodule

// File: rtl/seg_xlat.sv
module seg_xlat
  import seg_xlat_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int VA_W   = 16,
  parameter int PA_W   = 22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busReset,
  input  logic [1:0]        curMode,
  input  logic [1:0]        prevMode,
  input  logic              usePrev,
  input  logic              isData,
  input  logic [VA_W-1:0]   vaddr,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWData,
  output logic [REG_W-1:0]  regRData,
  output logic [PA_W-1:0]   physAddr
);
  localparam int CLICK_W = PA_W - REG_W;

  bankStrobe_t      strobe;
  logic [REG_W-1:0] bankRData;
  logic             mapEn, ext22;
  logic [MODES-1:0] dspEn;

  seg_xlat_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rst(rst), .busReset(busReset), .regWe(regWe),
    .regAddr(regAddr), .regWData(regWData), .bankRData(bankRData),
    .strobe(strobe), .mapEn(mapEn), .ext22(ext22), .dspEn(dspEn),
    .regRData(regRData)
  );

  seg_xlat_path #(.VA_W(VA_W), .CLICK_W(CLICK_W)) path_i (
    .clk(clk), .rst(rst), .strobe(strobe), .regWData(regWData),
    .bankRData(bankRData), .mapEn(mapEn), .ext22(ext22), .dspEn(dspEn),
    .curMode(curMode), .prevMode(prevMode), .usePrev(usePrev),
    .isData(isData), .vaddr(vaddr), .physAddr(physAddr)
  );
endmodule

// File: tb/seg_xlat_tb_top.sv
module seg_xlat_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 9;

  logic        clk = 1'b0;
  logic        rst, busReset, usePrev, isData, regWe;
  logic [1:0]  curMode, prevMode;
  logic [15:0] vaddr, regWData, regRData;
  logic [7:0]  regAddr;
  logic [21:0] physAddr;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_xlat dut_i (
    .clk(clk), .rst(rst), .busReset(busReset), .curMode(curMode),
    .prevMode(prevMode), .usePrev(usePrev), .isData(isData), .vaddr(vaddr),
    .regWe(regWe), .regAddr(regAddr), .regWData(regWData),
    .regRData(regRData), .physAddr(physAddr)
  );

  // {mode, isData, vaddr, expected}
  localparam logic [40:0] VEC [NVEC] = '{
    {2'd0, 1'b0, 16'o001234, 22'o001234},
    {2'd0, 1'b0, 16'o140100, 22'o140100},
    {2'd0, 1'b0, 16'o160000, 22'o760000},
    {2'd0, 1'b1, 16'o177776, 22'o777776},
    {2'd0, 1'b1, 16'o000100, 22'o000100},
    {2'd2, 1'b0, 16'o000100, 22'o100100},
    {2'd2, 1'b1, 16'o000100, 22'o102100},
    {2'd1, 1'b1, 16'o000010, 22'o200010},
    {2'd3, 1'b0, 16'o020000, 22'o000000}
  };

  function automatic logic [7:0] segAddr(input bit isBase, input logic [1:0] m,
                                         input bit dBank, input logic [2:0] seg);
    return {1'b0, isBase, m, dBank, seg};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%o expected=%o", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWData = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regCheck(input string req, input logic [7:0] a, input logic [15:0] exp);
    @(negedge clk);
    regAddr = a;
    #1 check(req, 32'(regRData), 32'(exp));
  endtask

  task automatic xlat(input string req, input logic [1:0] m, input bit d,
                      input logic [15:0] va, input logic [21:0] exp);
    @(negedge clk);
    curMode = m; isData = d; vaddr = va;
    @(posedge clk);
    #1 check(req, 32'(physAddr), 32'(exp));
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst = 1; busReset = 0; usePrev = 0; isData = 0; regWe = 0;
    curMode = 0; prevMode = 0; vaddr = 16'o012345; regWData = 0; regAddr = 8'h80;
    repeat (3) @(posedge clk);
    #1 check("R1 physAddr in reset", 32'(physAddr), 0);
    @(negedge clk); rst = 0;
    regCheck("R1 ctrl A after reset", 8'h80, 16'h0000);
    regCheck("R1 ctrl B after reset", 8'h81, 16'h0000);

    // translation off
    xlat("R4 flat pass", 2'd2, 1'b0, 16'o012345, 22'o012345);
    xlat("R4 flat io page", 2'd0, 1'b0, 16'o170000, 22'o770000);

    // register layout and masks
    regWrite(segAddr(0, 2'd0, 0, 3'd3), 16'hFFFF);
    regCheck("R3 descriptor mask", segAddr(0, 2'd0, 0, 3'd3), 16'o077417);
    regWrite(segAddr(1, 2'd3, 1, 3'd7), 16'hFFFF);
    regCheck("R3 base 16 bits via user alias", segAddr(1, 2'd2, 1, 3'd7), 16'hFFFF);
    regWrite(segAddr(1, 2'd2, 1, 3'd7), 16'h0000);
    regWrite(8'h80, 16'hFFFF);
    regCheck("R2 ctrl A mask", 8'h80, 16'h0111);
    regCheck("R2 ctrl B untouched", 8'h81, 16'h0000);
    regWrite(8'h81, 16'hFFFF);
    regCheck("R2 ctrl B mask", 8'h81, 16'h0037);

    // mapping setup
    for (int s = 0; s < 7; s++) regWrite(segAddr(1, 2'd0, 0, 3'(s)), 16'(s * 'o200));
    regWrite(segAddr(1, 2'd0, 0, 3'd7), 16'o177600);
    regWrite(segAddr(1, 2'd0, 1, 3'd7), 16'o177600);
    regWrite(segAddr(1, 2'd0, 1, 3'd0), 16'o000400);
    regWrite(segAddr(1, 2'd2, 0, 3'd0), 16'o001000);
    regWrite(segAddr(1, 2'd2, 1, 3'd0), 16'o001020);
    regWrite(segAddr(1, 2'd1, 0, 3'd0), 16'o002000);
    regWrite(8'h81, 16'h0001);
    regWrite(8'h80, 16'h0001);

    // table: R5 mapping, R6 bank fallback, R7 narrow
    for (int i = 0; i < NVEC; i++)
      xlat($sformatf("R5/R6 vector %0d", i), VEC[i][40:39], VEC[i][38],
           VEC[i][37:22], VEC[i][21:0]);

    // base step of one click
    regWrite(segAddr(1, 2'd0, 0, 3'd6), 16'o001401);
    xlat("R5 base plus one click", 2'd0, 1'b0, 16'o140000, 22'o140100);
    regWrite(segAddr(1, 2'd0, 0, 3'd6), 16'o171401);
    xlat("R7 upper base bits dropped", 2'd0, 1'b0, 16'o140000, 22'o140100);
    regWrite(8'h81, 16'o000021);
    xlat("R8 wide sum", 2'd0, 1'b0, 16'o140000, 22'o17140100);
    xlat("R8 kernel io page", 2'd0, 1'b0, 16'o160000, 22'o17760000);
    regWrite(segAddr(1, 2'd0, 0, 3'd6), 16'o001400);
    regWrite(8'h81, 16'h0001);

    // previous mode select
    @(negedge clk); usePrev = 1; prevMode = 2'd2;
    xlat("R10 previous mode data", 2'd0, 1'b1, 16'o000100, 22'o102100);
    @(negedge clk); usePrev = 0;
    xlat("R10 current mode again", 2'd0, 1'b1, 16'o000100, 22'o000100);

    // kernel data bank enable
    regWrite(8'h81, 16'o000005);
    xlat("R6 kernel data bank", 2'd0, 1'b1, 16'o000100, 22'o040100);

    // latency
    @(negedge clk); curMode = 2'd2; isData = 0; vaddr = 16'o000200;
    #1 check("R11 holds before edge", 32'(physAddr), 32'(22'o040100));
    @(posedge clk);
    #1 check("R11 updates after edge", 32'(physAddr), 32'(22'o100200));

    // bus reset
    @(negedge clk); busReset = 1;
    @(negedge clk); busReset = 0;
    regCheck("R9 ctrl A cleared", 8'h80, 16'h0000);
    regCheck("R9 ctrl B cleared", 8'h81, 16'h0000);
    xlat("R9 flat after bus reset", 2'd2, 1'b0, 16'o000200, 22'o000200);

    finish_run();
  end
endmodule